// File: doc/BRIEF.md
# Line clamp pulse generator

This block produces the clamp strobe that a three-channel video digitizer uses once per line to restore its black level. All timing is counted in pixel clock cycles. In internal mode, a window opens a programmable number of cycles after Hsync goes from its active to its inactive level, and it stays open for a programmable number of cycles. In external mode, an external clamp input is passed through to the output instead, and the window timing has no effect.

The external input is normalised to active high. By default it is taken as active high. An override bit lets the user declare the input active low. The window that the block generates itself is always active high. Each colour channel has a select bit that chooses its clamp target, and the block gates the common strobe into a ground strobe or a midscale strobe for each channel. All configuration values are plain inputs. They are expected to be quasi-static.

Top module: `ccg_line_clamp`

## Requirements
- R1: While reset is asserted, `clamp_o`, `clamp_gnd_o` and `clamp_mid_o` are all 0 for any input activity. Reset is released through a two-stage synchronizer, and the block ignores all inputs until the synchronizer has released.
- R2: In internal mode (`src_ext_i`=0), a trailing Hsync edge is seen at clock edge T. This is the first edge that samples `hsync_i` at its inactive level after an edge that sampled it active. The active level is set by the parameter `HS_ACT`. `clamp_o` stays 0 after edges T through T+P-1, where P is the placement value.
- R3: In internal mode, `clamp_o` is 1 after exactly D consecutive clock edges, T+P through T+P+D-1, where D is the duration value. It is 0 again after edge T+P+D.
- R4: A placement or duration value of 0 behaves as 1. The full range up to 255 (2^CNT_W-1) is honoured.
- R5: A trailing edge that arrives while a window is pending or open restarts timing from the new edge. The remainder of the earlier window is discarded.
- R6: Placement and duration are both captured at the trailing edge. A later change of `place_i` or `dur_i` affects only the next line.
- R7: In external mode (`src_ext_i`=1), `clamp_o` after edge k equals the normalised `ext_clamp_i` sampled at edge k. Placement, duration and Hsync have no effect on the output.
- R8: The normalised external clamp is `ext_clamp_i` inverted only when `pol_ovr_i`=1 and `pol_user_i`=0. It passes unchanged when `pol_ovr_i`=0, whatever the value of `pol_user_i`. The internally generated window never depends on these bits.
- R9: After each edge, for every channel c, `clamp_mid_o[c]` = `clamp_o` & `chan_mid_i[c]` and `clamp_gnd_o[c]` = `clamp_o` & ~`chan_mid_i[c]`. Here `chan_mid_i[c]` is the value sampled at that edge, and bit 0 is red, bit 1 green and bit 2 blue. All channels therefore strobe together.
- R10: Without a trailing edge, no window starts. Hsync held at either level for many lines' worth of cycles leaves `clamp_o` at 0 in internal mode once any earlier window has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hsync_i | input | 1 | Horizontal sync; its active level is set by `HS_ACT` |
| src_ext_i | input | 1 | 0: internally timed window, 1: external clamp input |
| place_i | input | CNT_W | Cycles from the trailing Hsync edge to the start of the window (0 behaves as 1) |
| dur_i | input | CNT_W | Window length in cycles (0 behaves as 1) |
| ext_clamp_i | input | 1 | External clamp strobe |
| pol_ovr_i | input | 1 | 1: the user sets the polarity of the external strobe |
| pol_user_i | input | 1 | Polarity of the external strobe under override: 1 active high, 0 active low |
| chan_mid_i | input | NUM_CH | Clamp target per channel: 0 ground, 1 midscale |
| clamp_o | output | 1 | Active-high clamp strobe, common to all channels |
| clamp_gnd_o | output | NUM_CH | Strobe for each channel clamped to ground |
| clamp_mid_o | output | NUM_CH | Strobe for each channel clamped to midscale |

## Verification
The bench builds the block with `HS_ACT`=0, so the trailing edge is a rise of `hsync_i` and the inverted sync sense is covered. It keeps `CNT_W`=8 and `NUM_CH`=3. With these values, both counter extremes (0 promoted to 1, and 255) fit into lines of a few hundred cycles, and each of the three channel selects is checked on its own. Random line lengths shorter than placement plus duration bring restarts within reach. Mode and polarity changes in the middle of a line show that the timer keeps running independently of the output selection.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  // Phase of the per-line clamp window timer.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HOLD = 2'd2
  } ccg_phase_e;

  localparam int unsigned CCG_SYNC_STAGES = 2;

endpackage

// File: rtl/ccg_rst_sync.sv
module ccg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_no = sh_q[STAGES-1];

endmodule

// File: rtl/ccg_trail_det.sv
module ccg_trail_det #(
  parameter logic HS_ACT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  output logic trail_o
);

  logic hs_q;

  // Reset to the inactive level so release never fakes an edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= ~HS_ACT;
    end else begin
      hs_q <= hsync_i;
    end
  end

  assign trail_o = (hs_q == HS_ACT) && (hsync_i != HS_ACT);

endmodule

// File: rtl/ccg_win_timer.sv
module ccg_win_timer
  import ccg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trail_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             hold_next_o,
  output ccg_phase_e       phase_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  ccg_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dur_q, dur_d;
  logic [CNT_W-1:0] place_eff, dur_eff;
  logic             run_en;

  assign place_eff = (place_i == '0) ? ONE : place_i;
  assign dur_eff   = (dur_i   == '0) ? ONE : dur_i;
  assign run_en    = trail_i || (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    dur_d   = dur_q;
    if (trail_i) begin
      phase_d = PH_WAIT;
      cnt_d   = place_eff - ONE;
      dur_d   = dur_eff;
    end else begin
      case (phase_q)
        PH_WAIT: begin
          if (cnt_q == '0) begin
            phase_d = PH_HOLD;
            cnt_d   = dur_q - ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_d = PH_IDLE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: begin
          phase_d = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dur_q   <= ONE;
    end else if (run_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      dur_q   <= dur_d;
    end
  end

  assign hold_next_o = (phase_d == PH_HOLD);
  assign phase_o     = phase_q;

endmodule

// File: rtl/ccg_out_stage.sv
module ccg_out_stage #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_ext_i,
  input  logic              ext_clamp_i,
  input  logic              pol_ovr_i,
  input  logic              pol_user_i,
  input  logic              win_i,
  input  logic [NUM_CH-1:0] chan_mid_i,
  output logic              clamp_o,
  output logic [NUM_CH-1:0] gnd_o,
  output logic [NUM_CH-1:0] mid_o
);

  logic              ext_norm;
  logic              clamp_d;
  logic              clamp_q;
  logic [NUM_CH-1:0] gnd_d, gnd_q;
  logic [NUM_CH-1:0] mid_d, mid_q;

  // Only a user-declared active-low input is inverted.
  assign ext_norm = ext_clamp_i ^ (pol_ovr_i & ~pol_user_i);
  assign clamp_d  = src_ext_i ? ext_norm : win_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      mid_d[c] = clamp_d &  chan_mid_i[c];
      gnd_d[c] = clamp_d & ~chan_mid_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clamp_q <= 1'b0;
      gnd_q   <= '0;
      mid_q   <= '0;
    end else begin
      clamp_q <= clamp_d;
      gnd_q   <= gnd_d;
      mid_q   <= mid_d;
    end
  end

  assign clamp_o = clamp_q;
  assign gnd_o   = gnd_q;
  assign mid_o   = mid_q;

endmodule

// File: rtl/ccg_line_clamp.sv
module ccg_line_clamp
  import ccg_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NUM_CH = 3,
  parameter logic        HS_ACT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              src_ext_i,
  input  logic [CNT_W-1:0]  place_i,
  input  logic [CNT_W-1:0]  dur_i,
  input  logic              ext_clamp_i,
  input  logic              pol_ovr_i,
  input  logic              pol_user_i,
  input  logic [NUM_CH-1:0] chan_mid_i,
  output logic              clamp_o,
  output logic [NUM_CH-1:0] clamp_gnd_o,
  output logic [NUM_CH-1:0] clamp_mid_o
);

  logic       rst_sync_n;
  logic       trail;
  logic       win_next;
  ccg_phase_e phase;

  ccg_rst_sync #(.STAGES(CCG_SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ccg_trail_det #(.HS_ACT(HS_ACT)) u_trail (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .hsync_i (hsync_i),
    .trail_o (trail)
  );

  ccg_win_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .trail_i     (trail),
    .place_i     (place_i),
    .dur_i       (dur_i),
    .hold_next_o (win_next),
    .phase_o     (phase)
  );

  ccg_out_stage #(.NUM_CH(NUM_CH)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .src_ext_i   (src_ext_i),
    .ext_clamp_i (ext_clamp_i),
    .pol_ovr_i   (pol_ovr_i),
    .pol_user_i  (pol_user_i),
    .win_i       (win_next),
    .chan_mid_i  (chan_mid_i),
    .clamp_o     (clamp_o),
    .gnd_o       (clamp_gnd_o),
    .mid_o       (clamp_mid_o)
  );

endmodule

// File: rtl/ccg_line_clamp_chk.sv
module ccg_line_clamp_chk
  import ccg_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input logic              clk_i,
  input logic              rst_sync_n,
  input logic              trail,
  input ccg_phase_e        phase,
  input logic              src_ext_i,
  input logic              ext_clamp_i,
  input logic              pol_ovr_i,
  input logic              pol_user_i,
  input logic              clamp_o,
  input logic [NUM_CH-1:0] clamp_gnd_o,
  input logic [NUM_CH-1:0] clamp_mid_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (phase == PH_IDLE && !trail) |=> (phase == PH_IDLE)); // R10

  AST_RESTART_WAIT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    trail |=> (phase == PH_WAIT)); // R5

  AST_HOLD_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (phase == PH_HOLD && !$past(src_ext_i)) |-> clamp_o); // R3

  AST_EXT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    src_ext_i |=> (clamp_o == ($past(ext_clamp_i) ^ ($past(pol_ovr_i) & ~$past(pol_user_i))))); // R7

  AST_CH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((clamp_gnd_o & clamp_mid_o) == '0)); // R9

  AST_CH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !clamp_o |-> ($countones({clamp_gnd_o, clamp_mid_o}) == 0)); // R9

endmodule

bind ccg_line_clamp ccg_line_clamp_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_sync_n  (rst_sync_n),
  .trail       (trail),
  .phase       (phase),
  .src_ext_i   (src_ext_i),
  .ext_clamp_i (ext_clamp_i),
  .pol_ovr_i   (pol_ovr_i),
  .pol_user_i  (pol_user_i),
  .clamp_o     (clamp_o),
  .clamp_gnd_o (clamp_gnd_o),
  .clamp_mid_o (clamp_mid_o)
);

// File: tb/ccg_line_clamp_tb.sv
`timescale 1ns/1ps
module ccg_line_clamp_tb;

  localparam int unsigned CNT_W  = 8;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned MAXCYC = 200000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              hsync;
  logic              src_ext;
  logic [CNT_W-1:0]  place;
  logic [CNT_W-1:0]  dur;
  logic              ext_clamp;
  logic              pol_ovr;
  logic              pol_user;
  logic [NUM_CH-1:0] chan_mid;
  logic              clamp;
  logic [NUM_CH-1:0] cl_gnd;
  logic [NUM_CH-1:0] cl_mid;

  always #2 clk = ~clk;

  ccg_line_clamp #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .HS_ACT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .src_ext_i(src_ext),
    .place_i(place), .dur_i(dur), .ext_clamp_i(ext_clamp),
    .pol_ovr_i(pol_ovr), .pol_user_i(pol_user), .chan_mid_i(chan_mid),
    .clamp_o(clamp), .clamp_gnd_o(cl_gnd), .clamp_mid_o(cl_mid)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // stimulus for the next edge
  bit                s_hs_act = 0;
  bit                s_ext_mode = 0;
  logic [CNT_W-1:0]  s_place = 8'd8;
  logic [CNT_W-1:0]  s_dur = 8'd20;
  bit                s_ext = 0, s_ovr = 0, s_user = 1;
  logic [NUM_CH-1:0] s_sel = '0;
  string             s_focus = "";

  // reference model state
  int    m_edge = 0, m_t0 = 0, m_p = 1, m_d = 1;
  bit    m_prev_act = 0, m_have = 0, m_zero = 0, m_retrig = 0;
  bit    e_valid = 0;
  logic  e_clamp;
  logic [NUM_CH-1:0] e_gnd, e_mid;
  string e_tag;

  function automatic int eff(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic bit ext_norm(input bit x, input bit ovr, input bit usr);
    return x ^ (ovr & ~usr);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    int dt;
    @(negedge clk);
    if (e_valid) begin
      n_chk++;
      if (clamp !== e_clamp) begin
        n_fail++;
        $display("FAIL %s edge %0d: clamp_o=%b expected %b", e_tag, m_edge, clamp, e_clamp);
      end
      n_chk++;
      if (cl_gnd !== e_gnd || cl_mid !== e_mid) begin
        n_fail++;
        $display("FAIL R9 edge %0d: gnd=%b mid=%b expected gnd=%b mid=%b",
                 m_edge, cl_gnd, cl_mid, e_gnd, e_mid);
      end
    end
    hsync     = s_hs_act ? 1'b0 : 1'b1;
    src_ext   = s_ext_mode;
    place     = s_place;
    dur       = s_dur;
    ext_clamp = s_ext;
    pol_ovr   = s_ovr;
    pol_user  = s_user;
    chan_mid  = s_sel;
    m_edge++;
    if (m_prev_act && !s_hs_act) begin
      m_retrig = m_have && ((m_edge - m_t0) < (m_p + m_d));
      m_have   = 1;
      m_t0     = m_edge;
      m_p      = eff(s_place);
      m_d      = eff(s_dur);
      m_zero   = (s_place == 0) || (s_dur == 0);
    end
    m_prev_act = s_hs_act;
    if (s_ext_mode) begin
      e_clamp = ext_norm(s_ext, s_ovr, s_user);
      e_tag   = s_ovr ? "R8" : "R7";
    end else begin
      dt      = m_edge - m_t0;
      e_clamp = m_have && (dt >= m_p) && (dt < m_p + m_d);
      if (m_zero)        e_tag = "R4";
      else if (m_retrig) e_tag = "R5";
      else if (e_clamp)  e_tag = "R3";
      else               e_tag = "R2";
    end
    if (s_focus != "") e_tag = s_focus;
    e_gnd   = e_clamp ? ~s_sel : '0;
    e_mid   = e_clamp ?  s_sel : '0;
    e_valid = 1;
  endtask

  task automatic rand_cycle_fields();
    s_ext  = 1'($urandom_range(1, 0));
    s_sel  = NUM_CH'($urandom_range(7, 0));
  endtask

  task automatic line(input int act_len, input int idle_len);
    s_hs_act = 1;
    for (int i = 0; i < act_len; i++) begin rand_cycle_fields(); step(); end
    s_hs_act = 0;
    for (int i = 0; i < idle_len; i++) begin rand_cycle_fields(); step(); end
  endtask

  initial begin
    #(4 * MAXCYC);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; hsync = 1; src_ext = 1; place = 0; dur = 0;
    ext_clamp = 1; pol_ovr = 0; pol_user = 1; chan_mid = '1;
    // R1: outputs quiet under reset even with an active external strobe
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hsync = ~hsync;
      n_chk++;
      if (clamp !== 1'b0 || cl_gnd !== '0 || cl_mid !== '0) begin
        n_fail++;
        $display("FAIL R1 reset: clamp=%b gnd=%b mid=%b expected 0 0 0", clamp, cl_gnd, cl_mid);
      end
    end
    @(negedge clk);
    hsync = 1; src_ext = 0; ext_clamp = 0;
    rst_n = 1;
    s_focus = "R1";
    for (int i = 0; i < 4; i++) step();
    s_focus = "";

    // R2 R3: default placement 8, duration 20
    s_place = 8'd8; s_dur = 8'd20;
    for (int i = 0; i < 3; i++) line(10, 60);
    // R4: zero values behave as one, then the full range
    s_place = 8'd0; s_dur = 8'd0;
    line(5, 10);
    s_place = 8'd1; s_dur = 8'd1;
    line(1, 6);
    s_place = 8'd255; s_dur = 8'd255;
    line(3, 520);
    // R5: restart while pending and while open
    s_place = 8'd30; s_dur = 8'd30;
    line(4, 20);
    line(4, 45);
    line(4, 80);
    // R6: values changed after the trailing edge belong to the next line
    s_place = 8'd12; s_dur = 8'd10;
    s_hs_act = 1; step(); step();
    s_hs_act = 0; step();
    s_focus = "R6";
    s_place = 8'd2; s_dur = 8'd60;
    for (int i = 0; i < 40; i++) begin rand_cycle_fields(); step(); end
    s_focus = "";
    line(2, 70);
    // R7 R8: external mode under all polarity settings, timer values scrambled
    s_ext_mode = 1;
    for (int k = 0; k < 4; k++) begin
      s_ovr = k[1]; s_user = k[0];
      s_place = CNT_W'($urandom_range(255, 0));
      s_dur = CNT_W'($urandom_range(255, 0));
      line(6, 30);
    end
    s_ext_mode = 0; s_ovr = 0; s_user = 1;
    // R10: sync held at each level produces no new window
    s_place = 8'd3; s_dur = 8'd4;
    line(2, 20);
    s_focus = "R10";
    s_hs_act = 1;
    for (int i = 0; i < 150; i++) begin rand_cycle_fields(); step(); end
    s_hs_act = 0;
    s_focus = "";
    for (int i = 0; i < 10; i++) step();
    s_focus = "R10";
    for (int i = 0; i < 300; i++) begin rand_cycle_fields(); step(); end
    s_focus = "";

    // constrained random lines
    for (int n = 0; n < 200; n++) begin
      int act_len, idle_len;
      act_len  = $urandom_range(12, 1);
      idle_len = $urandom_range(80, 1);
      if ($urandom_range(7, 0) == 0) s_place = ($urandom_range(1, 0) == 1) ? 8'd0 : 8'd255;
      else s_place = CNT_W'($urandom_range(40, 1));
      if ($urandom_range(7, 0) == 0) s_dur = ($urandom_range(1, 0) == 1) ? 8'd0 : 8'd200;
      else s_dur = CNT_W'($urandom_range(40, 1));
      s_ext_mode = ($urandom_range(3, 0) == 0);
      s_ovr  = 1'($urandom_range(1, 0));
      s_user = 1'($urandom_range(1, 0));
      line(act_len, idle_len);
    end
    s_ext_mode = 0;
    for (int i = 0; i < 5; i++) step();
    summary();
  end

endmodule